// File: doc/BRIEF.md
# Network Board Control and Parity Status

This block holds the control and status word of a network interface board and the two words that record a memory parity failure. Host software reaches it through a 16-bit word-addressed register port. From the status word it drives the reset line and the channel-attention strobe of the network controller, the release from loopback ("on-air"), and two interrupt enables. It merges the controller's own interrupt request with the parity-error flag into one host interrupt line.

A parity checker elsewhere on the board reports each failure with a 20-bit word address, a source flag and a byte-end flag. The first report is latched, and later ones are dropped until software acknowledges the capture. A four-bit strap gives bits 17 to 20 of the host base address of the board RAM. It is loaded while the block is in reset and reads back in the low nibble of the status word.

Top module: `nic_board_ctrl`

## Requirements
- R1: After a synchronous active-low reset, ctl_reset, ctl_attn, on_air and irq are 0, and the status word reads back as zero except that bits 3:0 hold strap_nib.
- R2: Status sits at word 1056, the parity control word at 1058 and the parity low-address word at 1059. Every other word in the window (map words 0–1023, PROM words 1024–1055, filler word 1057) reads 0 and ignores writes.
- R3: Status bits 15 (board reset), 14 (on-air), 13 (attention), 12 (interrupt enable), 11 (parity interrupt enable), 5 (P2 enable) and 4 (256K option) are written by the host and read back. ctl_reset follows bit 15 and on_air follows bit 14. Bits 10, 7 and 6 read 0.
- R4: Status bits 3:0 are read-only. They show the strap value loaded during reset and keep it when the strap changes later or when software writes those bits.
- R5: ctl_attn is high for exactly one cycle, the cycle after a status write that takes bit 13 from 0 to 1. Writing 1 while the bit is already 1 gives no pulse.
- R6: A status write with bit 15 set stores 0 in bits 14, 13, 12, 11 and 5, whatever was written to them, and gives no attention pulse. Bit 4 and the nibble are not affected.
- R7: Status bit 8 reads the controller interrupt input as registered one cycle earlier.
- R8: While no error is held, a parity report sets status bit 9. It captures the source in control bit 7, the end in control bit 6, address bits 19:16 in control bits 3:0 and address bits 15:0 in the low-address word. All other control bits read 0.
- R9: While status bit 9 is set, further parity reports do not change the captured fields.
- R10: A write to the parity control word with bit 8 set clears status bit 9. Bit 8 always reads 0, other bits of that write are ignored, and writes to the low-address word are ignored.
- R11: When an acknowledge and a parity report fall in the same cycle, the new report is captured and bit 9 stays set.
- R12: irq = (bit 8 AND bit 12) OR (bit 9 AND bit 11), from the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_nib | input | 4 | Base-address strap, loaded during reset |
| reg_addr | input | 11 | Word address within the register window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ctl_irq_in | input | 1 | Interrupt request from the network controller |
| perr_valid | input | 1 | Parity failure report |
| perr_addr | input | 20 | Word address of the failure |
| perr_src | input | 1 | Source of the failing access |
| perr_end | input | 1 | Which byte end of the word failed |
| ctl_reset | output | 1 | Reset to the network controller |
| ctl_attn | output | 1 | One-cycle channel-attention strobe |
| on_air | output | 1 | Release from loopback |
| irq | output | 1 | Host interrupt request |
| base_nib | output | 4 | RAM base address bits 17–20 |

## Verification
Two pairs of events can land on the same clock edge. The first is an acknowledge write and a fresh parity report. The bench provokes it on purpose and checks that the new address, source and end are held with the flag still set. It then checks the opposite order, a report one cycle after the acknowledge. The second is a status write that changes an interrupt enable in the same cycle as the controller interrupt input toggles, and a random phase repeats such collisions many times. In both cases a behavioural model applies the requirements to the same inputs, and its irq, flags and read data are compared with the block on every clock.

// File: rtl/nic_board_pkg.sv
// Package: bit positions of the board status and parity control words.
// Assumes 16-bit registers; positions are fixed because software decodes them.
package nic_board_pkg;

    localparam int REG_W      = 16;

    // status word
    localparam int ST_BRST    = 15;
    localparam int ST_ONAIR   = 14;
    localparam int ST_ATTN    = 13;
    localparam int ST_IEN     = 12;
    localparam int ST_PEIEN   = 11;
    localparam int ST_PFLAG   = 9;
    localparam int ST_IFLAG   = 8;
    localparam int ST_P2EN    = 5;
    localparam int ST_RAM256  = 4;
    localparam int NIB_W      = 4;

    // parity control word
    localparam int PC_ACK     = 8;
    localparam int PC_SRC     = 7;
    localparam int PC_END     = 6;

    // captured parity failure
    typedef struct packed {
        logic        src;
        logic        ends;
        logic [19:0] addr;
    } perr_cap_t;

endpackage

// File: rtl/nic_bc_status.sv
// Module: holds the writable status bits, the base-address nibble and the
// attention strobe. Assumes wr_stat is already decoded for the status word.
module nic_bc_status
    import nic_board_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic [REG_W-1:0] wdata,
    input  logic [NIB_W-1:0] strap_nib,
    output logic             board_rst,
    output logic             on_air,
    output logic             attn_bit,
    output logic             ien,
    output logic             peien,
    output logic             p2en,
    output logic             ram256,
    output logic [NIB_W-1:0] nib,
    output logic             attn_pulse
);

    logic brst_q, onair_q, attn_q, ien_q, peien_q, p2en_q, ram_q;
    logic [NIB_W-1:0] nib_q;
    logic pulse_q;

    // Purpose: load status bits on write; a board reset write clears enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brst_q  <= 1'b0;
            onair_q <= 1'b0;
            attn_q  <= 1'b0;
            ien_q   <= 1'b0;
            peien_q <= 1'b0;
            p2en_q  <= 1'b0;
            ram_q   <= 1'b0;
            nib_q   <= strap_nib;
        end else if (wr_stat) begin
            brst_q <= wdata[ST_BRST];
            ram_q  <= wdata[ST_RAM256];
            if (wdata[ST_BRST]) begin
                onair_q <= 1'b0;
                attn_q  <= 1'b0;
                ien_q   <= 1'b0;
                peien_q <= 1'b0;
                p2en_q  <= 1'b0;
            end else begin
                onair_q <= wdata[ST_ONAIR];
                attn_q  <= wdata[ST_ATTN];
                ien_q   <= wdata[ST_IEN];
                peien_q <= wdata[ST_PEIEN];
                p2en_q  <= wdata[ST_P2EN];
            end
        end
    end

    // Purpose: one-cycle strobe on a 0->1 write of the attention bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= wr_stat & ~wdata[ST_BRST] & wdata[ST_ATTN] & ~attn_q;
    end

    assign board_rst  = brst_q;
    assign on_air     = onair_q;
    assign attn_bit   = attn_q;
    assign ien        = ien_q;
    assign peien      = peien_q;
    assign p2en       = p2en_q;
    assign ram256     = ram_q;
    assign nib        = nib_q;
    assign attn_pulse = pulse_q;

    AST_ATTN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        attn_pulse |=> !attn_pulse); // R5
    AST_ATTN_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        attn_pulse |-> attn_bit); // R5
    AST_BRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[ST_BRST]) |=> (!on_air && !ien && !peien && !attn_bit && !p2en && !attn_pulse)); // R6
    AST_NIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(nib)); // R4

endmodule

// File: rtl/nic_bc_parity.sv
// Module: latches the first parity failure and holds it until acknowledged.
// Assumes err_valid is a single-cycle report; an acknowledge in the same cycle
// as a report releases the old capture and keeps the new one.
module nic_bc_parity
    import nic_board_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      err_valid,
    input  perr_cap_t err_in,
    input  logic      ack,
    output logic      flag,
    output perr_cap_t cap
);

    logic      flag_q;
    perr_cap_t cap_q;
    logic      take;

    // Purpose: capture when nothing is held, or when an ack frees the slot.
    always_comb take = err_valid & (~flag_q | ack);

    // Purpose: flag set on capture, cleared by ack without a new report.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (take)   flag_q <= 1'b1;
        else if (ack)    flag_q <= 1'b0;
    end

    // Purpose: store address, source and end of the captured failure.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_q <= '0;
        else if (take) cap_q <= err_in;
    end

    assign flag = flag_q;
    assign cap  = cap_q;

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> ($stable(cap) && flag)); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !err_valid) |=> !flag); // R10
    AST_ACK_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && err_valid) |=> (flag && cap == $past(err_in))); // R11
    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !flag) |=> (flag && cap == $past(err_in))); // R8

endmodule

// File: rtl/nic_bc_irq.sv
// Module: registers the controller interrupt and merges it with the parity
// flag into the host request. Assumes ctl_irq_in is synchronous to clk.
module nic_bc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_irq_in,
    input  logic ien,
    input  logic peien,
    input  logic pflag,
    output logic iflag,
    output logic irq
);

    logic iflag_q;

    // Purpose: sample the controller request into the status flag.
    always_ff @(posedge clk) begin
        if (!rst_n) iflag_q <= 1'b0;
        else        iflag_q <= ctl_irq_in;
    end

    // Purpose: host request from either enabled source.
    always_comb irq = (iflag_q & ien) | (pflag & peien);

    assign iflag = iflag_q;

    AST_IFLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_irq_in |=> iflag); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien && !peien) |-> !irq); // R12

endmodule

// File: rtl/nic_board_ctrl.sv
// Module: top of the board control block. Decodes the register window,
// builds the read words and connects status, parity and interrupt logic.
// Assumes word addressing; map and PROM words live elsewhere and read 0 here.
module nic_board_ctrl
    import nic_board_pkg::*;
#(
    parameter int MAP_WORDS  = 1024,
    parameter int PROM_WORDS = 32,
    parameter int ADDR_W     = 11,
    parameter int PADDR_W    = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIB_W-1:0]     strap_nib,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 ctl_irq_in,
    input  logic                 perr_valid,
    input  logic [PADDR_W-1:0]   perr_addr,
    input  logic                 perr_src,
    input  logic                 perr_end,
    output logic                 ctl_reset,
    output logic                 ctl_attn,
    output logic                 on_air,
    output logic                 irq,
    output logic [NIB_W-1:0]     base_nib
);

    localparam int LO_W  = REG_W;
    localparam int HI_W  = PADDR_W - LO_W;
    localparam logic [ADDR_W-1:0] IDX_STAT  = ADDR_W'(MAP_WORDS + PROM_WORDS);
    localparam logic [ADDR_W-1:0] IDX_PCTL  = ADDR_W'(MAP_WORDS + PROM_WORDS + 2);
    localparam logic [ADDR_W-1:0] IDX_PLOW  = ADDR_W'(MAP_WORDS + PROM_WORDS + 3);

    logic sel_stat, sel_pctl, sel_plow;
    logic wr_stat, ack;
    logic brst, onair_b, attn_b, ien_b, peien_b, p2en_b, ram_b, pulse;
    logic [NIB_W-1:0] nib;
    logic pflag, iflag, irq_w;
    perr_cap_t cap, err_in;

    // Purpose: decode the three words this block owns.
    always_comb begin
        sel_stat = (reg_addr == IDX_STAT);
        sel_pctl = (reg_addr == IDX_PCTL);
        sel_plow = (reg_addr == IDX_PLOW);
        wr_stat  = reg_wr & sel_stat;
        ack      = reg_wr & sel_pctl & reg_wdata[PC_ACK];
    end

    // Purpose: pack the incoming parity report.
    always_comb begin
        err_in      = '0;
        err_in.src  = perr_src;
        err_in.ends = perr_end;
        err_in.addr = 20'(perr_addr);
    end

    nic_bc_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (wr_stat),
        .wdata      (reg_wdata),
        .strap_nib  (strap_nib),
        .board_rst  (brst),
        .on_air     (onair_b),
        .attn_bit   (attn_b),
        .ien        (ien_b),
        .peien      (peien_b),
        .p2en       (p2en_b),
        .ram256     (ram_b),
        .nib        (nib),
        .attn_pulse (pulse)
    );

    nic_bc_parity u_parity (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_valid (perr_valid),
        .err_in    (err_in),
        .ack       (ack),
        .flag      (pflag),
        .cap       (cap)
    );

    nic_bc_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_irq_in (ctl_irq_in),
        .ien        (ien_b),
        .peien      (peien_b),
        .pflag      (pflag),
        .iflag      (iflag),
        .irq        (irq_w)
    );

    // Purpose: read multiplexer; unowned words return zero.
    always_comb begin
        reg_rdata = '0;
        if (sel_stat) begin
            reg_rdata[ST_BRST]    = brst;
            reg_rdata[ST_ONAIR]   = onair_b;
            reg_rdata[ST_ATTN]    = attn_b;
            reg_rdata[ST_IEN]     = ien_b;
            reg_rdata[ST_PEIEN]   = peien_b;
            reg_rdata[ST_PFLAG]   = pflag;
            reg_rdata[ST_IFLAG]   = iflag;
            reg_rdata[ST_P2EN]    = p2en_b;
            reg_rdata[ST_RAM256]  = ram_b;
            reg_rdata[NIB_W-1:0]  = nib;
        end else if (sel_pctl) begin
            reg_rdata[PC_SRC]     = cap.src;
            reg_rdata[PC_END]     = cap.ends;
            reg_rdata[HI_W-1:0]   = cap.addr[PADDR_W-1:LO_W];
        end else if (sel_plow) begin
            reg_rdata             = cap.addr[LO_W-1:0];
        end
    end

    assign ctl_reset = brst;
    assign ctl_attn  = pulse;
    assign on_air    = onair_b;
    assign irq       = irq_w;
    assign base_nib  = nib;

    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pctl |-> !reg_rdata[PC_ACK]); // R10
    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (iflag || pflag)); // R12
    AST_RESET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_stat) |=> (ctl_reset == $past(reg_wdata[ST_BRST]))); // R3

endmodule

// File: tb/nic_board_ctrl_tb.sv
`timescale 1ns/1ps
module nic_board_ctrl_tb_top;

    localparam int STAT = 1056;
    localparam int PCTL = 1058;
    localparam int PLOW = 1059;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_nib = 4'hA;
    logic [10:0] reg_addr = 11'(STAT);
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ctl_irq_in = 1'b0;
    logic        perr_valid = 1'b0;
    logic [19:0] perr_addr = '0;
    logic        perr_src = 1'b0;
    logic        perr_end = 1'b0;
    logic        ctl_reset, ctl_attn, on_air, irq;
    logic [3:0]  base_nib;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nic_board_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .strap_nib(strap_nib),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ctl_irq_in(ctl_irq_in),
        .perr_valid(perr_valid), .perr_addr(perr_addr),
        .perr_src(perr_src), .perr_end(perr_end),
        .ctl_reset(ctl_reset), .ctl_attn(ctl_attn), .on_air(on_air),
        .irq(irq), .base_nib(base_nib)
    );

    // behavioural reference state
    bit m_brst, m_onair, m_attn, m_ien, m_peien, m_p2, m_ram, m_pulse;
    bit m_iflag, m_pflag, m_src, m_end;
    bit [3:0]  m_nib;
    bit [19:0] m_addr;

    always @(posedge clk) begin
        bit ack, stw;
        if (!rst_n) begin
            {m_brst, m_onair, m_attn, m_ien, m_peien, m_p2, m_ram, m_pulse} = '0;
            {m_iflag, m_pflag, m_src, m_end} = '0;
            m_addr = '0;
            m_nib = strap_nib;
        end else begin
            stw = reg_wr && reg_addr == 11'(STAT);
            ack = reg_wr && reg_addr == 11'(PCTL) && reg_wdata[8];
            m_pulse = stw && !reg_wdata[15] && reg_wdata[13] && !m_attn;
            if (stw) begin
                m_brst = reg_wdata[15];
                m_ram  = reg_wdata[4];
                m_onair = reg_wdata[15] ? 1'b0 : reg_wdata[14];
                m_attn  = reg_wdata[15] ? 1'b0 : reg_wdata[13];
                m_ien   = reg_wdata[15] ? 1'b0 : reg_wdata[12];
                m_peien = reg_wdata[15] ? 1'b0 : reg_wdata[11];
                m_p2    = reg_wdata[15] ? 1'b0 : reg_wdata[5];
            end
            m_iflag = ctl_irq_in;
            if (perr_valid && (!m_pflag || ack)) begin
                m_pflag = 1'b1;
                m_addr = perr_addr; m_src = perr_src; m_end = perr_end;
            end else if (ack) begin
                m_pflag = 1'b0;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        logic [15:0] r = '0;
        case (int'(reg_addr))
            STAT: r = {m_brst, m_onair, m_attn, m_ien, m_peien, 1'b0, m_pflag, m_iflag,
                       2'b00, m_p2, m_ram, m_nib};
            PCTL: r = {7'b0, 1'b0, m_src, m_end, 2'b00, m_addr[19:16]};
            PLOW: r = m_addr[15:0];
            default: r = '0;
        endcase
        return r;
    endfunction

    // compare every output against the model
    task automatic compare_all();
        string rt;
        if (!rst_n) begin
            chk("R1 ctl_reset", ctl_reset, 0);
            chk("R1 ctl_attn", ctl_attn, 0);
            return;
        end
        case (int'(reg_addr))
            STAT: rt = "R3 status read";
            PCTL: rt = "R8 parity ctrl read";
            PLOW: rt = "R8 parity low read";
            default: rt = "R2 unowned read";
        endcase
        chk(rt, reg_rdata, exp_rdata());
        chk("R3 ctl_reset", ctl_reset, m_brst);
        chk("R3 on_air", on_air, m_onair);
        chk("R5 ctl_attn", ctl_attn, m_pulse);
        chk("R4 base_nib", base_nib, m_nib);
        chk("R12 irq", irq, (m_iflag & m_ien) | (m_pflag & m_peien));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int a, logic [15:0] d);
        reg_addr = 11'(a); reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a);
        reg_addr = 11'(a);
        tick();
    endtask

    task automatic perr(logic [19:0] a, logic s, logic e);
        perr_valid = 1'b1; perr_addr = a; perr_src = s; perr_end = e;
        tick();
        perr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        rd(STAT);
        chk("R1 status after reset", reg_rdata, 16'h000A);
        chk("R1 irq after reset", irq, 0);

        // R3: writable bits read back
        wr(STAT, 16'h5830);
        rd(STAT);
        chk("R3 written bits", reg_rdata, 16'h583A);
        chk("R3 on_air high", on_air, 1);

        // R5: attention pulse, then none on a repeated 1
        wr(STAT, 16'h7830);
        chk("R5 attn pulse", ctl_attn, 1);
        tick();
        chk("R5 attn one cycle", ctl_attn, 0);
        wr(STAT, 16'h7830);
        chk("R5 no pulse when already set", ctl_attn, 0);
        wr(STAT, 16'h5830);

        // R4: nibble read-only and held against strap change
        strap_nib = 4'h3;
        wr(STAT, 16'h583F);
        rd(STAT);
        chk("R4 nibble held", reg_rdata[3:0], 4'hA);

        // R6: board reset write clears enables, keeps 256K and nibble
        wr(STAT, 16'hF830);
        rd(STAT);
        chk("R6 board reset clears", reg_rdata, 16'h801A);
        chk("R6 ctl_reset high", ctl_reset, 1);
        wr(STAT, 16'h0000);
        chk("R6 ctl_reset released", ctl_reset, 0);

        // R7 / R12: controller interrupt through enable
        wr(STAT, 16'h1000);
        ctl_irq_in = 1'b1;
        tick();
        chk("R7 iflag set", reg_rdata[8], 1);
        chk("R12 irq from controller", irq, 1);
        wr(STAT, 16'h0000);
        chk("R12 irq masked", irq, 0);
        ctl_irq_in = 1'b0;
        tick();

        // R8: first capture
        wr(STAT, 16'h0800);
        perr(20'hB1234, 1'b1, 1'b0);
        rd(PCTL);
        chk("R8 ctrl capture", reg_rdata, 16'h008B);
        rd(PLOW);
        chk("R8 low capture", reg_rdata, 16'h1234);
        chk("R12 irq from parity", irq, 1);

        // R9: later report dropped
        perr(20'h5FFFF, 1'b0, 1'b1);
        rd(PLOW);
        chk("R9 low held", reg_rdata, 16'h1234);
        rd(PCTL);
        chk("R9 ctrl held", reg_rdata, 16'h008B);

        // R10: writes to low word ignored; ack clears, reads 0
        wr(PLOW, 16'hFFFF);
        rd(PLOW);
        chk("R10 low write ignored", reg_rdata, 16'h1234);
        wr(PCTL, 16'h01FF);
        rd(STAT);
        chk("R10 flag cleared", reg_rdata[9], 0);
        rd(PCTL);
        chk("R10 ack reads 0", reg_rdata[8], 0);
        chk("R10 irq dropped", irq, 0);

        // R11: ack with a new report in the same cycle
        perr(20'h20001, 1'b0, 1'b0);
        perr_valid = 1'b1; perr_addr = 20'hC4321; perr_src = 1'b1; perr_end = 1'b1;
        wr(PCTL, 16'h0100);
        perr_valid = 1'b0;
        rd(STAT);
        chk("R11 flag stays set", reg_rdata[9], 1);
        rd(PLOW);
        chk("R11 new low captured", reg_rdata, 16'h4321);
        rd(PCTL);
        chk("R11 new ctrl captured", reg_rdata, 16'h00CC);
        wr(PCTL, 16'h0100);
        perr(20'h00777, 1'b0, 1'b1);
        rd(PLOW);
        chk("R11 report after ack captured", reg_rdata, 16'h0777);

        // R2: unowned words read 0 and writes do not land
        wr(5, 16'hFFFF);   rd(5);    chk("R2 map word", reg_rdata, 0);
        wr(1030, 16'hFFFF); rd(1030); chk("R2 prom word", reg_rdata, 0);
        wr(1057, 16'hFFFF); rd(1057); chk("R2 filler word", reg_rdata, 0);
        rd(STAT);
        chk("R2 status untouched", reg_rdata[15:10], 6'b000010);

        // random phase: collisions of writes, reports and controller irq
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 5);
            case (sel)
                0, 1: reg_addr = 11'(STAT);
                2: reg_addr = 11'(PCTL);
                3: reg_addr = 11'(PLOW);
                4: reg_addr = 11'($urandom_range(0, 1057));
                default: reg_addr = 11'(STAT);
            endcase
            reg_wr = ($urandom_range(0, 2) == 0);
            reg_wdata = 16'($urandom);
            if ($urandom_range(0, 3) != 0) reg_wdata[15] = 1'b0;
            ctl_irq_in = ($urandom_range(0, 1) == 1);
            perr_valid = ($urandom_range(0, 4) == 0);
            perr_addr = 20'($urandom);
            perr_src = 1'($urandom);
            perr_end = 1'($urandom);
            tick();
        end
        reg_wr = 1'b0; perr_valid = 1'b0;
        tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule